// File: doc/BRIEF.md
# Ordered mailbox FIFO channel

This block is a single one-way mailbox channel built around an in-order queue. A sender pushes payload words, each tagged with a flag that asks for an acknowledgment. A receiver takes them off the head in the order they went in. The sender may queue several words without waiting, as long as there is free space.

The channel raises level interrupts toward both sides. The receiver sees a data-available line. Two fill-level watermarks, each with its own programmable threshold, drive the low and high tide lines. A flush event has its own line. The sender sees an acknowledge line. A flush empties the queue in one cycle and drops any acknowledgment that was still owed. A push into a full queue is refused and leaves a sticky overflow flag.

Acknowledgment works in two steps. First, the receiver pops an entry whose request flag is set. Then it strobes its acknowledge input. Only after both steps does the sender's acknowledge line go high.

Top module: `mbx_fifo_chan`

## Requirements
- R1: `rcv_data_o` always shows the oldest queued word while the level is nonzero, and words leave in exactly the order they were pushed.
- R2: `rcv_level_o` rises by one in the cycle after an accepted push and falls by one after an accepted pop. A push and a pop in the same cycle on a non-empty queue leave it unchanged. `rcv_xfer_irq_o` is high exactly when the level is nonzero.
- R3: A push while the queue is full and no pop is accepted is refused. The level and contents stay as they are. `snd_ovf_o` is set the next cycle and stays set until `snd_ovf_clr_i` is pulsed. A set in the same cycle wins over the clear. `snd_full_o` is high exactly when the level equals DEPTH.
- R4: On a full queue, a push and a pop in the same cycle are both accepted. The level stays at DEPTH and no overflow is flagged.
- R5: A pop on an empty queue is ignored and the level stays 0. If a push comes in the same cycle, the push is still accepted.
- R6: `low_tide_irq_o` is high exactly while the level is at or below `low_thr_i`.
- R7: `high_tide_irq_o` is high exactly while the level is at or above `high_thr_i`.
- R8: A `snd_flush_i` pulse makes the level 0 in the next cycle. Any push or pop in that cycle is discarded. `flush_irq_o` goes high and stays high until `rcv_flush_clr_i` is pulsed.
- R9: After the receiver pops an entry whose request bit is 1, an `rcv_ack_i` pulse sets `snd_ack_irq_o` in the next cycle. It stays set until `snd_ack_clr_i` is pulsed.
- R10: An `rcv_ack_i` pulse has no effect when no acknowledgment is owed. This includes the case where a flush came after the pop of a requesting entry.
- R11: `rcv_ackreq_o` shows the request bit of the head entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_push_i | input | 1 | Push request |
| snd_data_i | input | DATA_W | Payload word to push |
| snd_ackreq_i | input | 1 | Request acknowledgment for this word |
| snd_flush_i | input | 1 | Flush strobe |
| snd_ovf_clr_i | input | 1 | Write-1-to-clear for overflow |
| snd_ack_clr_i | input | 1 | Write-1-to-clear for acknowledge |
| snd_full_o | output | 1 | Queue full |
| snd_ovf_o | output | 1 | Sticky overflow flag |
| snd_ack_irq_o | output | 1 | Acknowledge interrupt (level) |
| rcv_pop_i | input | 1 | Pop head entry |
| rcv_ack_i | input | 1 | Acknowledge strobe |
| rcv_flush_clr_i | input | 1 | Write-1-to-clear for flush flag |
| rcv_data_o | output | DATA_W | Head payload word |
| rcv_ackreq_o | output | 1 | Head request bit |
| rcv_level_o | output | $clog2(DEPTH+1) | Fill level |
| rcv_xfer_irq_o | output | 1 | Data-available interrupt |
| low_thr_i | input | $clog2(DEPTH+1) | Low tide threshold |
| high_thr_i | input | $clog2(DEPTH+1) | High tide threshold |
| low_tide_irq_o | output | 1 | Low tide interrupt |
| high_tide_irq_o | output | 1 | High tide interrupt |
| flush_irq_o | output | 1 | Flush interrupt |

## Verification
The queue is driven through a fixed push/pop sequence that covers:
- lone pushes and lone pops;
- simultaneous push and pop at a middle level, at full and at empty;
- a refused push while full.

Together these separate correct ordering and pointer wrap from off-by-one level counting. They also separate the full case from the empty case when push and pop coincide. Both tide lines are checked at every step, so a wrong comparison operator shows up at the threshold level.

Directed sequences cover the acknowledge path in three forms: an acknowledge owed, an acknowledge with nothing owed, and an owed acknowledge cancelled by a flush. A flush that coincides with a push is also covered.

// File: rtl/mbx_fifo_pkg.sv
package mbx_fifo_pkg;
    // sticky status flags of one channel
    typedef struct packed {
        logic ovf;
        logic flushed;
    } chan_sts_t;

    // acknowledge tracking state
    typedef struct packed {
        logic owed;
        logic pend;
    } ack_st_t;
endpackage

// File: rtl/mbx_fifo_store.sv
module mbx_fifo_store #(
    parameter int W     = 33,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         wr_en_i,
    input  logic                         rd_en_i,
    input  logic [W-1:0]                 wdata_i,
    output logic [W-1:0]                 rdata_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [LW-1:0]           cnt;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (wr_en_i) begin
                st_d.mem[st_q.wr] = wdata_i;
                st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
            end
            if (rd_en_i) begin
                st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
            end
            case ({wr_en_i, rd_en_i})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.mem[st_q.rd];
    assign count_o = st_q.cnt;
endmodule

// File: rtl/mbx_tide_cmp.sv
module mbx_tide_cmp #(
    parameter int LW = 4
) (
    input  logic [LW-1:0] level_i,
    input  logic [LW-1:0] low_thr_i,
    input  logic [LW-1:0] high_thr_i,
    output logic          low_o,
    output logic          high_o
);
    always_comb begin
        low_o  = (level_i <= low_thr_i);
        high_o = (level_i >= high_thr_i);
    end
endmodule

// File: rtl/mbx_ack_track.sv
module mbx_ack_track
    import mbx_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic pop_ok_i,
    input  logic head_req_i,
    input  logic ack_i,
    input  logic clr_i,
    output logic pend_o
);
    ack_st_t ack_d, ack_q;

    always_comb begin
        ack_d = ack_q;
        // an ack owed by the receiver is consumed by its strobe
        if (flush_i)                   ack_d.owed = 1'b0;
        else if (pop_ok_i && head_req_i) ack_d.owed = 1'b1;
        else if (ack_i)                ack_d.owed = 1'b0;
        // set wins over the sender's clear
        if (ack_i && ack_q.owed && !flush_i) ack_d.pend = 1'b1;
        else if (clr_i)                      ack_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= ack_d;
    end

    assign pend_o = ack_q.pend;
endmodule

// File: rtl/mbx_fifo_chan.sv
module mbx_fifo_chan
    import mbx_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       snd_push_i,
    input  logic [DATA_W-1:0]          snd_data_i,
    input  logic                       snd_ackreq_i,
    input  logic                       snd_flush_i,
    input  logic                       snd_ovf_clr_i,
    input  logic                       snd_ack_clr_i,
    output logic                       snd_full_o,
    output logic                       snd_ovf_o,
    output logic                       snd_ack_irq_o,
    input  logic                       rcv_pop_i,
    input  logic                       rcv_ack_i,
    input  logic                       rcv_flush_clr_i,
    output logic [DATA_W-1:0]          rcv_data_o,
    output logic                       rcv_ackreq_o,
    output logic [$clog2(DEPTH+1)-1:0] rcv_level_o,
    output logic                       rcv_xfer_irq_o,
    input  logic [$clog2(DEPTH+1)-1:0] low_thr_i,
    input  logic [$clog2(DEPTH+1)-1:0] high_thr_i,
    output logic                       low_tide_irq_o,
    output logic                       high_tide_irq_o,
    output logic                       flush_irq_o
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int EW = DATA_W + 1;

    logic [LW-1:0] count;
    logic [EW-1:0] head;
    logic          full, pop_ok, push_ok;
    chan_sts_t     sts_d, sts_q;

    assign full    = (count == LW'(DEPTH));
    assign pop_ok  = rcv_pop_i && (count != '0) && !snd_flush_i;
    assign push_ok = snd_push_i && !snd_flush_i && (!full || pop_ok);

    mbx_fifo_store #(.W(EW), .DEPTH(DEPTH)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (snd_flush_i),
        .wr_en_i (push_ok),
        .rd_en_i (pop_ok),
        .wdata_i ({snd_ackreq_i, snd_data_i}),
        .rdata_o (head),
        .count_o (count)
    );

    mbx_tide_cmp #(.LW(LW)) i_tide (
        .level_i    (count),
        .low_thr_i  (low_thr_i),
        .high_thr_i (high_thr_i),
        .low_o      (low_tide_irq_o),
        .high_o     (high_tide_irq_o)
    );

    mbx_ack_track i_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (snd_flush_i),
        .pop_ok_i   (pop_ok),
        .head_req_i (head[EW-1]),
        .ack_i      (rcv_ack_i),
        .clr_i      (snd_ack_clr_i),
        .pend_o     (snd_ack_irq_o)
    );

    always_comb begin
        sts_d = sts_q;
        if (snd_push_i && !snd_flush_i && !push_ok) sts_d.ovf = 1'b1;
        else if (snd_ovf_clr_i)                     sts_d.ovf = 1'b0;
        if (snd_flush_i)          sts_d.flushed = 1'b1;
        else if (rcv_flush_clr_i) sts_d.flushed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign snd_full_o     = full;
    assign snd_ovf_o      = sts_q.ovf;
    assign flush_irq_o    = sts_q.flushed;
    assign rcv_data_o     = head[DATA_W-1:0];
    assign rcv_ackreq_o   = head[EW-1];
    assign rcv_level_o    = count;
    assign rcv_xfer_irq_o = (count != '0);
endmodule

// File: rtl/mbx_fifo_chan_chk.sv
module mbx_fifo_chan_chk #(
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          snd_push_i,
    input logic          snd_flush_i,
    input logic          snd_ovf_clr_i,
    input logic          snd_ack_clr_i,
    input logic          rcv_pop_i,
    input logic          rcv_ack_i,
    input logic          rcv_flush_clr_i,
    input logic [LW-1:0] rcv_level_o,
    input logic          snd_ovf_o,
    input logic          snd_ack_irq_o,
    input logic          flush_irq_o
);
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_level_o <= LW'(DEPTH));

    a_r2_push_pop_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_push_i && rcv_pop_i && !snd_flush_i && rcv_level_o != '0) |=> $stable(rcv_level_o));

    a_r3_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_push_i && !rcv_pop_i && !snd_flush_i && rcv_level_o == LW'(DEPTH)) |=> (rcv_level_o == LW'(DEPTH)) && snd_ovf_o);

    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_ovf_o && !snd_ovf_clr_i) |=> snd_ovf_o);

    a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_pop_i && !snd_push_i && rcv_level_o == '0) |=> rcv_level_o == '0);

    a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        snd_flush_i |=> (rcv_level_o == '0) && flush_irq_o);

    a_r8_flush_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_irq_o && !rcv_flush_clr_i) |=> flush_irq_o);

    a_r9_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_ack_clr_i && !rcv_ack_i) |=> !snd_ack_irq_o);

    a_r10_no_ack_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!rcv_ack_i && !snd_ack_irq_o) |=> !snd_ack_irq_o);
endmodule

bind mbx_fifo_chan mbx_fifo_chan_chk #(.DEPTH(DEPTH), .LW($clog2(DEPTH + 1))) i_chk (.*);

// File: tb/test_mbx_fifo_chan.sv
module test_mbx_fifo_chan;
    localparam int DW = 16;
    localparam int DEPTH = 4;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snd_push = 0, snd_ackreq = 0, snd_flush = 0, snd_ovf_clr = 0, snd_ack_clr = 0;
    logic rcv_pop = 0, rcv_ack = 0, rcv_flush_clr = 0;
    logic [DW-1:0] snd_data = '0;
    logic [LW-1:0] low_thr = LW'(1), high_thr = LW'(3);
    logic snd_full, snd_ovf, snd_ack_irq, rcv_ackreq, rcv_xfer_irq;
    logic low_irq, high_irq, flush_irq;
    logic [DW-1:0] rcv_data;
    logic [LW-1:0] rcv_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mbx_fifo_chan #(.DATA_W(DW), .DEPTH(DEPTH)) i_mbx_fifo_chan (
        .clk(clk), .rst_n(rst_n),
        .snd_push_i(snd_push), .snd_data_i(snd_data), .snd_ackreq_i(snd_ackreq),
        .snd_flush_i(snd_flush), .snd_ovf_clr_i(snd_ovf_clr), .snd_ack_clr_i(snd_ack_clr),
        .snd_full_o(snd_full), .snd_ovf_o(snd_ovf), .snd_ack_irq_o(snd_ack_irq),
        .rcv_pop_i(rcv_pop), .rcv_ack_i(rcv_ack), .rcv_flush_clr_i(rcv_flush_clr),
        .rcv_data_o(rcv_data), .rcv_ackreq_o(rcv_ackreq), .rcv_level_o(rcv_level),
        .rcv_xfer_irq_o(rcv_xfer_irq), .low_thr_i(low_thr), .high_thr_i(high_thr),
        .low_tide_irq_o(low_irq), .high_tide_irq_o(high_irq), .flush_irq_o(flush_irq)
    );

    typedef struct packed {
        logic          push;
        logic          pop;
        logic [DW-1:0] data;
        logic [2:0]    lvl;
        logic [DW-1:0] head;
    } vec_t;

    // push, pop, data, expected level after, expected head after
    localparam vec_t VECS [16] = '{
        '{1'b1, 1'b0, 16'hA001, 3'd1, 16'hA001},
        '{1'b1, 1'b0, 16'hA002, 3'd2, 16'hA001},
        '{1'b1, 1'b1, 16'hA003, 3'd2, 16'hA002},
        '{1'b0, 1'b1, 16'h0000, 3'd1, 16'hA003},
        '{1'b1, 1'b0, 16'hA004, 3'd2, 16'hA003},
        '{1'b1, 1'b0, 16'hA005, 3'd3, 16'hA003},
        '{1'b1, 1'b0, 16'hA006, 3'd4, 16'hA003},
        '{1'b1, 1'b0, 16'hA007, 3'd4, 16'hA003},  // R3 refused
        '{1'b1, 1'b1, 16'hA008, 3'd4, 16'hA004},  // R4 push+pop at full
        '{1'b0, 1'b1, 16'h0000, 3'd3, 16'hA005},
        '{1'b0, 1'b1, 16'h0000, 3'd2, 16'hA006},
        '{1'b0, 1'b1, 16'h0000, 3'd1, 16'hA008},
        '{1'b0, 1'b1, 16'h0000, 3'd0, 16'h0000},
        '{1'b0, 1'b1, 16'h0000, 3'd0, 16'h0000},  // R5 pop on empty
        '{1'b1, 1'b1, 16'hA009, 3'd1, 16'hA009},  // R5 push kept
        '{1'b0, 1'b1, 16'h0000, 3'd0, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        snd_push = 0; rcv_pop = 0; snd_flush = 0; snd_ovf_clr = 0;
        snd_ack_clr = 0; rcv_ack = 0; rcv_flush_clr = 0; snd_ackreq = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state
        check("R2 reset level", 32'(rcv_level), 0);
        check("R2 reset xfer", 32'(rcv_xfer_irq), 0);
        check("R6 reset low", 32'(low_irq), 1);
        check("R7 reset high", 32'(high_irq), 0);
        check("R8 reset flush", 32'(flush_irq), 0);
        check("R9 reset ack", 32'(snd_ack_irq), 0);
        check("R3 reset ovf", 32'(snd_ovf), 0);

        for (int i = 0; i < 16; i++) begin
            snd_push = VECS[i].push;
            rcv_pop  = VECS[i].pop;
            snd_data = VECS[i].data;
            tick();
            check("R2/R4/R5 level", 32'(rcv_level), 32'(VECS[i].lvl));
            if (VECS[i].lvl != 0) check("R1 head", 32'(rcv_data), 32'(VECS[i].head));
            check("R2 xfer", 32'(rcv_xfer_irq), 32'(VECS[i].lvl != 0));
            check("R6 low", 32'(low_irq), 32'(VECS[i].lvl <= 1));
            check("R7 high", 32'(high_irq), 32'(VECS[i].lvl >= 3));
            check("R3 full", 32'(snd_full), 32'(VECS[i].lvl == 4));
        end

        // R3 overflow sticky, then cleared
        check("R3 ovf sticky", 32'(snd_ovf), 1);
        snd_ovf_clr = 1; tick();
        check("R3 ovf clear", 32'(snd_ovf), 0);

        // R7 threshold moved
        high_thr = LW'(2);
        snd_push = 1; snd_data = 16'h0B01; tick();
        snd_push = 1; snd_data = 16'h0B02; tick();
        check("R7 high at new thr", 32'(high_irq), 1);
        check("R6 low above thr", 32'(low_irq), 0);

        // R8 flush with simultaneous push
        snd_flush = 1; snd_push = 1; snd_data = 16'h0B03; tick();
        check("R8 flush level", 32'(rcv_level), 0);
        check("R8 flush irq", 32'(flush_irq), 1);
        rcv_flush_clr = 1; tick();
        check("R8 flush clear", 32'(flush_irq), 0);
        check("R8 push discarded", 32'(rcv_level), 0);

        // R9 / R11 acknowledge path
        snd_push = 1; snd_ackreq = 1; snd_data = 16'hBEEF; tick();
        check("R11 head req", 32'(rcv_ackreq), 1);
        check("R1 head ack word", 32'(rcv_data), 32'h0000BEEF);
        rcv_pop = 1; tick();
        check("R9 ack before strobe", 32'(snd_ack_irq), 0);
        rcv_ack = 1; tick();
        check("R9 ack set", 32'(snd_ack_irq), 1);
        snd_ack_clr = 1; tick();
        check("R9 ack clear", 32'(snd_ack_irq), 0);

        // R10 strobe with nothing owed
        rcv_ack = 1; tick();
        check("R10 stray ack", 32'(snd_ack_irq), 0);
        snd_push = 1; snd_ackreq = 0; snd_data = 16'h0C01; tick();
        check("R11 head no req", 32'(rcv_ackreq), 0);
        rcv_pop = 1; tick();
        rcv_ack = 1; tick();
        check("R10 ack of unrequested", 32'(snd_ack_irq), 0);

        // R10 flush cancels owed ack
        snd_push = 1; snd_ackreq = 1; snd_data = 16'h0C02; tick();
        rcv_pop = 1; tick();
        snd_flush = 1; tick();
        rcv_ack = 1; tick();
        check("R10 ack after flush", 32'(snd_ack_irq), 0);

        finish_run();
    end
endmodule